// File: doc/BRIEF.md
# Tagged Event Playback Generator

This block replays byte data that software has preloaded into a storage queue, standing in for the readout side of a chain of front-end chips. Each stored word is nine bits wide: a data byte plus a tag bit that marks the final word of an event. Software pushes words through a simple write strobe. Several events can sit in the queue one after another. Each Readout phase drains exactly one of them.

An external readout clock is oversampled by the faster system clock. Every transition of that clock, rising or falling, counts as one read strobe. While the mode input selects Readout, each strobe presents the next stored byte on the output bus. When a tagged word has been presented, or when the queue has run dry, a token flip-flop raises priority-out and freezes the queue. The whole chain is represented by one contiguous block with no separators. Leaving Readout drops the token, so the next event is ready for the following Readout phase. Status outputs report full, empty, end-of-event and a sticky overflow flag. A clear pulse empties the queue.

Top module: `evt_playback`

## Requirements
- R1: After reset, dout is 0, prio_out, stat_eoe, stat_full and stat_ovf are 0, and stat_empty is 1.
- R2: A stored word places the data byte in wr_word[7:0] and the end-of-event tag in wr_word[8]. Only bits 7:0 ever appear on dout.
- R3: While mode equals 2'b11 (Readout) and prio_out is low, each rising and each falling transition of ext_clk pops the oldest word onto dout. The new byte is visible within 4 system clock cycles. ext_clk holds each level for at least 2 system cycles.
- R4: Once a word with bit 8 set has been presented, prio_out and stat_eoe go high. Further ext_clk transitions leave dout and the stored words unchanged until Readout is left.
- R5: While in Readout with the queue empty, prio_out goes high on the next cycle. This includes a queue emptied by an untagged final word.
- R6: One cycle after mode differs from 2'b11, prio_out is low. The next Readout phase continues with the word that follows the last tagged word.
- R7: ext_clk transitions while mode is not 2'b11 pop nothing and leave dout unchanged.
- R8: stat_full is 1 exactly when DEPTH words are stored, and stat_empty is 1 exactly when none are.
- R9: A write while the queue is full is discarded and sets stat_ovf. stat_ovf stays set until fifo_clr.
- R10: A fifo_clr pulse discards all stored words and clears stat_ovf.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than ext_clk transitions |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe for one stored word |
| wr_word | input | 9 | Word to store: tag in bit 8, byte in bits 7:0 |
| fifo_clr | input | 1 | Pulse that empties the queue and clears overflow |
| ext_clk | input | 1 | External readout clock, asynchronous |
| mode | input | 2 | Operating mode, 2'b11 selects Readout |
| dout | output | 8 | Presented data byte |
| prio_out | output | 1 | Token: block finished or queue exhausted |
| stat_full | output | 1 | Queue holds DEPTH words |
| stat_empty | output | 1 | Queue holds no words |
| stat_eoe | output | 1 | End-of-event status, follows the token |
| stat_ovf | output | 1 | Sticky flag for a write dropped when full |

## Verification
Several properties are checked on every cycle. The token holds while Readout persists and falls once Readout is left. dout moves only on a pop. The queue never pops while empty. A full queue with no pop stays full, and the overflow flag is sticky. Other behaviour is visible only through the bench scenarios: the exact byte order across dual-edge strobes, the split between back-to-back events over successive Readout phases, and the loss of the word written into a full queue. The bench checks these against a queue model driven by seeded random events and directed corner cases.

// File: rtl/evt_pkg.sv
package evt_pkg;
   localparam int BYTE_W = 8;
   localparam int WORD_W = BYTE_W + 1;

   typedef struct packed {
      logic              last;
      logic [BYTE_W-1:0] data;
   } evt_word_t;
endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic strobe
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[gi] <= 1'b0;
               else        sync_q[gi] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[gi] <= 1'b0;
               else        sync_q[gi] <= sync_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[SYNC_STAGES-1];
   end

   // either edge of the synchronised level yields one strobe
   assign strobe = sync_q[SYNC_STAGES-1] ^ last_q;
endmodule

// File: rtl/evt_fifo.sv
module evt_fifo #(
   parameter int DEPTH = 2048,
   parameter int WIDTH = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             full,
   output logic             empty,
   output logic             ovf
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = AW + 1;
   localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
   localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (WIDTH < 2) begin : g_bad_width
         $error("WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]    cnt;
   logic             do_wr, do_rd;

   generate
      if (POW2) begin : g_wrap_nat
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign full    = (cnt == CNT_MAX);
   assign empty   = (cnt == '0);
   assign do_wr   = wr_en && !full && !clr;
   assign do_rd   = rd_en && !empty && !clr;
   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_nxt;
         if (do_rd) rd_ptr <= rd_nxt;
         case ({do_wr, do_rd})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr)       ovf <= 1'b0;
      else if (wr_en && full)  ovf <= 1'b1;
   end

   p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_en && !clr) |=> full);
   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr) |=> ovf);
   p_empty_no_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !rd_en);
   p_clr_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (empty && !ovf));
endmodule

// File: rtl/evt_playback.sv
module evt_playback
   import evt_pkg::*;
#(
   parameter int         DEPTH       = 2048,
   parameter int         SYNC_STAGES = 2,
   parameter logic [1:0] RO_MODE     = 2'b11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [WORD_W-1:0] wr_word,
   input  logic              fifo_clr,
   input  logic              ext_clk,
   input  logic [1:0]        mode,
   output logic [BYTE_W-1:0] dout,
   output logic              prio_out,
   output logic              stat_full,
   output logic              stat_empty,
   output logic              stat_eoe,
   output logic              stat_ovf
);
   logic      strobe, in_ro, pop, tok_q;
   logic      q_empty;
   evt_word_t head;

   evt_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ext_clk),
      .strobe   (strobe)
   );

   evt_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (fifo_clr),
      .wr_en   (wr_valid),
      .wr_data (wr_word),
      .rd_en   (pop),
      .rd_data (head),
      .full    (stat_full),
      .empty   (q_empty),
      .ovf     (stat_ovf)
   );

   assign in_ro = (mode == RO_MODE);
   assign pop   = in_ro && !tok_q && strobe && !q_empty && !fifo_clr;

   always_ff @(posedge clk) begin
      if (!rst_n)              tok_q <= 1'b0;
      else if (!in_ro)         tok_q <= 1'b0;
      else if (pop && head.last) tok_q <= 1'b1;
      else if (q_empty)        tok_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   dout <= '0;
      else if (pop) dout <= head.data;
   end

   assign prio_out   = tok_q;
   assign stat_eoe   = tok_q;
   assign stat_empty = q_empty;

   p_token_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (prio_out && in_ro) |=> prio_out);
   p_token_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ro |=> !prio_out);
   p_dout_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pop |=> $stable(dout));
   p_no_pop_with_token_r4: assert property (@(posedge clk) disable iff (!rst_n)
      prio_out |-> !pop);
endmodule

// File: tb/evt_playback_test.sv
module evt_playback_test;
   localparam int TD = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_valid = 1'b0;
   logic [8:0] wr_word = '0;
   logic       fifo_clr = 1'b0;
   logic       ext_clk = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [7:0] dout;
   logic       prio_out, stat_full, stat_empty, stat_eoe, stat_ovf;

   int n_chk = 0;
   int n_fail = 0;
   logic [8:0] q_m [$];
   logic [7:0] dout_m = '0;
   logic       tok_m = 1'b0;
   logic       ovf_m = 1'b0;
   logic [1:0] mode_m = 2'b00;

   always #2 clk = ~clk;

   evt_playback #(.DEPTH(TD)) uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
      .fifo_clr(fifo_clr), .ext_clk(ext_clk), .mode(mode), .dout(dout),
      .prio_out(prio_out), .stat_full(stat_full), .stat_empty(stat_empty),
      .stat_eoe(stat_eoe), .stat_ovf(stat_ovf)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic mdl_empty();
      return q_m.size() == 0;
   endfunction

   task automatic check_all(input string req);
      chk(req, "dout", int'(dout), int'(dout_m));
      chk(req, "prio_out", int'(prio_out), int'(tok_m));
      chk(req, "stat_eoe", int'(stat_eoe), int'(tok_m));
      chk(req, "stat_empty", int'(stat_empty), int'(mdl_empty()));
      chk(req, "stat_full", int'(stat_full), int'(q_m.size() == TD));
      chk(req, "stat_ovf", int'(stat_ovf), int'(ovf_m));
   endtask

   task automatic settle();
      if (mode_m == 2'b11 && mdl_empty()) tok_m = 1'b1;
   endtask

   task automatic push(input logic [8:0] w);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_word  = w;
      @(negedge clk);
      wr_valid = 1'b0;
      if (q_m.size() < TD) q_m.push_back(w);
      else ovf_m = 1'b1;
      repeat (2) @(negedge clk);
      settle();
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(negedge clk);
      mode = m;
      mode_m = m;
      if (m != 2'b11) tok_m = 1'b0;
      repeat (3) @(negedge clk);
      settle();
   endtask

   task automatic toggle();
      logic [8:0] w;
      @(negedge clk);
      ext_clk = ~ext_clk;
      repeat (6) @(negedge clk);
      if (mode_m == 2'b11 && !tok_m && !mdl_empty()) begin
         w = q_m.pop_front();
         dout_m = w[7:0];
         if (w[8]) tok_m = 1'b1;
      end
      settle();
   endtask

   task automatic clear_q();
      @(negedge clk);
      fifo_clr = 1'b1;
      @(negedge clk);
      fifo_clr = 1'b0;
      q_m.delete();
      ovf_m = 1'b0;
      repeat (2) @(negedge clk);
      settle();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int unsigned seed_v;
      seed_v = $urandom(32'd2718);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // R2 R3 R4: two events back to back, dual-edge playback
      push(9'h0A5); push(9'h05A); push(9'h1C3);
      push(9'h011); push(9'h122);
      check_all("R2");
      set_mode(2'b11);
      for (int i = 0; i < 3; i++) begin toggle(); check_all("R3"); end
      for (int i = 0; i < 3; i++) begin toggle(); check_all("R4"); end
      // R7: transitions outside Readout
      set_mode(2'b01);
      check_all("R6");
      for (int i = 0; i < 3; i++) begin toggle(); check_all("R7"); end
      // R6: next event on the next Readout phase
      set_mode(2'b11);
      for (int i = 0; i < 3; i++) begin toggle(); check_all("R6"); end
      set_mode(2'b00);

      // R5: untagged tail runs dry
      push(9'h077); push(9'h088);
      set_mode(2'b11);
      for (int i = 0; i < 3; i++) begin toggle(); check_all("R5"); end
      set_mode(2'b10);
      set_mode(2'b11);
      check_all("R5");
      set_mode(2'b00);

      // R8 R9: fill, overflow, drain
      for (int i = 0; i < TD; i++) push(9'(i + 8'h40));
      check_all("R8");
      push(9'h1FF);
      check_all("R9");
      set_mode(2'b11);
      for (int i = 0; i < TD + 1; i++) begin toggle(); check_all("R9"); end
      set_mode(2'b00);
      check_all("R9");

      // R10: clear pulse
      push(9'h033); push(9'h044);
      clear_q();
      check_all("R10");

      // random events
      for (int e = 0; e < 40; e++) begin
         int len;
         len = 1 + int'($urandom_range(5));
         for (int k = 0; k < len; k++)
            push({(k == len - 1) ? 1'b1 : 1'b0, 8'($urandom)});
         if ($urandom_range(3) == 0) begin toggle(); check_all("R7"); end
         set_mode(2'b11);
         for (int k = 0; k < len + int'($urandom_range(2)); k++) begin
            toggle(); check_all("R3");
         end
         set_mode(2'($urandom_range(2)));
         check_all("R6");
         if ($urandom_range(7) == 0) begin clear_q(); check_all("R10"); end
      end
      finish_run();
   end
endmodule